// File: doc/BRIEF.md
# I2C Transfer Sequencer with 10-bit Addressing

This block walks a status-coded I2C master engine through one complete read or write transfer without processor help. A single `start` pulse captures the target address (7-bit or 10-bit), the direction and a byte count. From then on the sequencer waits for the engine's interrupt flag, reads the engine's status code, and answers with one action: a control-word write, optionally preceded by a data-register write carrying an address byte or a data byte.

For writes, bytes are taken from an input stream: `tx_data` must hold the next byte, and `tx_pop` marks the cycle in which it is consumed. For reads, each byte the engine captures is delivered as a one-cycle `rx_valid` pulse with `rx_data`.

The sequencer builds both 10-bit address bytes itself. It drops the acknowledge bit before the final read byte so that the target sees a NACK. It honours a level-sensitive abort request. When it returns to idle, it pulses `done` together with a result code: 0 means OK, 1 means no device answered, and 2 means the controller reported an unexpected status.

Top module: `i2c_xfer_seq`

## Requirements
- R1: When idle, a `start` pulse latches the transfer parameters, clears `err` to 0 and writes the control word 0x64. The control word bit positions are: bit 2 acknowledge, bit 4 STOP, bit 5 START, bit 6 enable, bit 7 interrupt enable. A `start` while a transfer is running produces no output activity.
- R2: On status 0x08 or 0x10 the first address byte is written to the data register, followed by the control word 0x44. In 7-bit mode this byte is {addr[6:0], rd}. In 10-bit mode it is 0xF0 | addr[9:8]<<1 | rd, where rd=1 means read.
- R3: In 10-bit mode, status 0x18 or 0x40 writes the second address byte addr[7:0] before any data is moved.
- R4: On a write acknowledge (0x18 in 7-bit mode, 0xD0, 0x28) with bytes remaining, the sequencer writes `tx_data`, pulses `tx_pop` and decrements the count. With no bytes remaining it writes STOP and finishes with result 0.
- R5: A pending abort ends a write with STOP at the next write acknowledge only after at least one data byte has been sent. Before that, the abort has no effect.
- R6: On a read address acknowledge (0x40 in 7-bit mode, 0xE0) with a zero count, the sequencer writes STOP and finishes with result 0 (a probe). Otherwise it writes the control word without capturing data.
- R7: Status 0x50 delivers `eng_rdata` on `rx_data` and decrements the count. Status 0x58 delivers the byte, writes STOP and finishes with result 0. The acknowledge bit is cleared from every later control word once one byte remains to be read, or when an abort is pending.
- R8: Status 0x20, 0x30 or 0x48 writes STOP and finishes with result 1.
- R9: Any other status during a transfer pulses `eng_srst`, writes the control word 0x50 and finishes with result 2.
- R10: Every STOP control word has bit 7 (interrupt enable) clear. It equals the current control word with bit 4 set.
- R11: A flag seen while idle is answered with the control word 0x50, and `done` stays low.
- R12: `done` is high for exactly one cycle per finished transfer. `err` holds its value until the next accepted `start`.
- R13: After any control write, the flag must be seen low at least once before the next status is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| rd | input | 1 | 1 = read, 0 = write |
| ten_bit | input | 1 | 1 = 10-bit target address |
| addr | input | 10 | Target address |
| len | input | LEN_W | Byte count |
| abort | input | 1 | Abort request (level) |
| tx_data | input | 8 | Next write byte |
| tx_pop | output | 1 | `tx_data` consumed this cycle |
| rx_valid | output | 1 | `rx_data` valid |
| rx_data | output | 8 | Received byte |
| eng_iflg | input | 1 | Engine interrupt flag |
| eng_status | input | 8 | Engine status code |
| eng_rdata | input | 8 | Engine data register read value |
| eng_data_we | output | 1 | Write `eng_data` to engine data register |
| eng_data | output | 8 | Address or data byte for the engine |
| eng_ctrl_we | output | 1 | Write `eng_ctrl` to engine control register |
| eng_ctrl | output | 8 | Control word |
| eng_srst | output | 1 | Engine soft reset pulse |
| done | output | 1 | Transfer finished (one cycle) |
| err | output | 2 | Result: 0 OK, 1 no device, 2 I/O error |

## Verification
The bench plays the engine and issues scripted status sequences:
- a 7-bit write, to separate the data path from the address path;
- a 10-bit read and a 10-bit write, to check both address bytes and the ACK drop before the last byte;
- a zero-length read, to separate a probe from a data read;
- a NACKed address and an illegal status, to tell the two error codes apart.

Abort is applied before and after the first write byte, which shows the at-least-one-byte rule, and during a read, which shows the early NACK. A leftover flag while idle, and a `start` pulse in mid-transfer, confirm that the sequencer ignores or merely answers traffic outside its own transfer.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd,
  input  logic             ten_bit,
  input  logic [9:0]       addr,
  input  logic [LEN_W-1:0] len,
  input  logic             abort,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic             eng_iflg,
  input  logic [7:0]       eng_status,
  input  logic [7:0]       eng_rdata,
  output logic             eng_data_we,
  output logic [7:0]       eng_data,
  output logic             eng_ctrl_we,
  output logic [7:0]       eng_ctrl,
  output logic             eng_srst,
  output logic             done,
  output logic [1:0]       err
);
  localparam logic [7:0] C_ACK = 8'h04;
  localparam logic [7:0] C_STP = 8'h10;
  localparam logic [7:0] C_STA = 8'h20;
  localparam logic [7:0] C_EN  = 8'h40;
  localparam logic [7:0] C_IE  = 8'h80;
  localparam logic [7:0] C_RUN = C_ACK | C_EN;

  logic             busy, armed, rd_q, ten_q, abort_q, sent;
  logic [9:0]       addr_q;
  logic [LEN_W-1:0] cnt;
  logic [7:0]       cbits;

  wire       fire  = eng_iflg && armed;
  wire       abt   = abort_q || abort;
  wire [7:0] a1    = ten_q ? {5'b11110, addr_q[9:8], rd_q} : {addr_q[6:0], rd_q};
  wire [7:0] a2    = addr_q[7:0];
  wire [7:0] nack  = cbits & ~C_ACK;
  wire [7:0] stopw = (cbits & ~C_IE) | C_STP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; armed <= 1'b1; rd_q <= 1'b0; ten_q <= 1'b0;
      abort_q <= 1'b0; sent <= 1'b0; addr_q <= '0; cnt <= '0; cbits <= C_RUN;
      tx_pop <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
      eng_data_we <= 1'b0; eng_data <= '0; eng_ctrl_we <= 1'b0; eng_ctrl <= '0;
      eng_srst <= 1'b0; done <= 1'b0; err <= 2'd0;
    end else begin
      tx_pop <= 1'b0; rx_valid <= 1'b0; eng_data_we <= 1'b0;
      eng_ctrl_we <= 1'b0; eng_srst <= 1'b0; done <= 1'b0;
      if (!eng_iflg) armed <= 1'b1;
      if (busy && abort) abort_q <= 1'b1;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; rd_q <= rd; ten_q <= ten_bit; addr_q <= addr;
          cnt <= len; abort_q <= 1'b0; sent <= 1'b0; cbits <= C_RUN; err <= 2'd0;
          eng_ctrl_we <= 1'b1; eng_ctrl <= C_RUN | C_STA; armed <= 1'b0;
        end else if (fire) begin
          eng_ctrl_we <= 1'b1; eng_ctrl <= C_EN | C_STP; armed <= 1'b0;
        end
      end else if (fire) begin
        armed <= 1'b0;
        eng_ctrl_we <= 1'b1;
        eng_ctrl <= cbits;
        unique case (eng_status)
          8'h08, 8'h10: begin
            eng_data_we <= 1'b1; eng_data <= a1;
          end
          8'h18, 8'hD0, 8'h28: begin
            if (ten_q && eng_status == 8'h18) begin
              eng_data_we <= 1'b1; eng_data <= a2;
            end else if (cnt == '0 || (abt && sent)) begin
              eng_ctrl <= stopw; cbits <= cbits & ~C_IE; busy <= 1'b0; done <= 1'b1; err <= 2'd0;
            end else begin
              eng_data_we <= 1'b1; eng_data <= tx_data; tx_pop <= 1'b1;
              cnt <= cnt - 1'b1; sent <= 1'b1;
            end
          end
          8'h40, 8'hE0: begin
            if (ten_q && eng_status == 8'h40) begin
              eng_data_we <= 1'b1; eng_data <= a2;
            end else if (cnt == '0) begin
              eng_ctrl <= stopw; cbits <= cbits & ~C_IE; busy <= 1'b0; done <= 1'b1; err <= 2'd0;
            end else if (cnt == 1 || abt) begin
              cbits <= nack; eng_ctrl <= nack;
            end
          end
          8'h50: begin
            rx_valid <= 1'b1; rx_data <= eng_rdata; cnt <= cnt - 1'b1;
            if (cnt == 2 || abt) begin
              cbits <= nack; eng_ctrl <= nack;
            end
          end
          8'h58: begin
            rx_valid <= 1'b1; rx_data <= eng_rdata;
            eng_ctrl <= stopw; cbits <= cbits & ~C_IE; busy <= 1'b0; done <= 1'b1; err <= 2'd0;
          end
          8'h20, 8'h30, 8'h48: begin
            eng_ctrl <= stopw; cbits <= cbits & ~C_IE; busy <= 1'b0; done <= 1'b1; err <= 2'd1;
          end
          default: begin
            eng_srst <= 1'b1; eng_ctrl <= C_EN | C_STP; cbits <= C_RUN;
            busy <= 1'b0; done <= 1'b1; err <= 2'd2;
          end
        endcase
      end
    end
  end
endmodule

module i2c_xfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_ctrl_we,
  input logic [7:0] eng_ctrl,
  input logic       eng_data_we,
  input logic       eng_srst,
  input logic       tx_pop,
  input logic       done,
  input logic [1:0] err
);
  a_r10_stop_no_inten: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ctrl_we && eng_ctrl[4]) |-> !eng_ctrl[7]);
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_srst_is_ioerr: assert property (@(posedge clk) disable iff (!rst_n)
    eng_srst |-> (done && err == 2'd2 && eng_ctrl_we));
  a_r4_pop_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (eng_data_we && eng_ctrl_we));
  a_r1_start_word: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ctrl_we && eng_ctrl[5]) |-> (eng_ctrl[2] && eng_ctrl[6] && !eng_ctrl[4]));
  a_r12_err_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && err != 2'd0) |=> (err == $past(err) || err == 2'd0 || done));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_ctrl_we(eng_ctrl_we), .eng_ctrl(eng_ctrl),
  .eng_data_we(eng_data_we), .eng_srst(eng_srst), .tx_pop(tx_pop),
  .done(done), .err(err)
);

// File: tb/i2c_xfer_seq_bench.sv
module i2c_xfer_seq_bench;
  logic clk = 0, rst_n = 0;
  logic start = 0, rd = 0, ten_bit = 0, abort = 0, eng_iflg = 0;
  logic [9:0] addr = 0;
  logic [7:0] len = 0, tx_data = 0, eng_status = 0, eng_rdata = 0;
  logic tx_pop, rx_valid, eng_data_we, eng_ctrl_we, eng_srst, done;
  logic [7:0] rx_data, eng_data, eng_ctrl;
  logic [1:0] err;

  i2c_xfer_seq u_i2c_xfer_seq (.*);

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit x_dwe, x_cwe, x_srst, x_pop, x_rxv, x_done;
  logic [7:0] x_d, x_c, x_rx;
  logic [1:0] x_err = 0;
  string tag = "R12";
  bit live = 0;

  task automatic bad(string what, int act, int exp);
    miscompares++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  always @(negedge clk) if (live) begin
    vectors++;
    if (eng_data_we !== x_dwe) bad("data_we", eng_data_we, x_dwe);
    else if (x_dwe && eng_data !== x_d) bad("data", eng_data, x_d);
    if (eng_ctrl_we !== x_cwe) bad("ctrl_we", eng_ctrl_we, x_cwe);
    else if (x_cwe && eng_ctrl !== x_c) bad("ctrl", eng_ctrl, x_c);
    if (eng_srst !== x_srst) bad("srst", eng_srst, x_srst);
    if (tx_pop !== x_pop) bad("tx_pop", tx_pop, x_pop);
    if (rx_valid !== x_rxv) bad("rx_valid", rx_valid, x_rxv);
    else if (x_rxv && rx_data !== x_rx) bad("rx_data", rx_data, x_rx);
    if (done !== x_done) bad("done", done, x_done);
    if (err !== x_err) bad("err", err, x_err);
  end

  task automatic clr;
    {x_dwe, x_cwe, x_srst, x_pop, x_rxv, x_done} = '0;
  endtask

  // one engine event: flag + status, then the expected reply in the following cycle
  task automatic ev(string t, logic [7:0] st, logic [7:0] rdat, bit dwe, logic [7:0] d,
                    logic [7:0] c, bit srst, bit pop, bit rxv, bit dn, logic [1:0] e);
    @(posedge clk); #1;
    eng_iflg = 1; eng_status = st; eng_rdata = rdat;
    @(posedge clk); #1;
    tag = t; eng_iflg = 0;
    x_dwe = dwe; x_d = d; x_cwe = 1; x_c = c; x_srst = srst; x_pop = pop;
    x_rxv = rxv; x_rx = rdat; x_done = dn; if (dn) x_err = e;
    @(posedge clk); #1; clr;
  endtask

  task automatic go(string t, bit r, bit ten, logic [9:0] a, logic [7:0] n);
    @(posedge clk); #1;
    start = 1; rd = r; ten_bit = ten; addr = a; len = n;
    @(posedge clk); #1;
    tag = t; start = 0; x_cwe = 1; x_c = 8'h64; x_err = 0;
    @(posedge clk); #1; clr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    clr;
    repeat (3) @(posedge clk);
    #1; rst_n = 1; live = 1; tag = "R12";
    idle(2);                                   // reset state: all quiet, err 0

    // R1 R2 R4: 7-bit write 0x50, two bytes; mid-transfer start ignored (R1)
    go("R1", 0, 0, 10'h050, 2);
    ev("R2", 8'h08, 0, 1, 8'hA0, 8'h44, 0, 0, 0, 0, 0);
    tx_data = 8'h11;
    ev("R4", 8'h18, 0, 1, 8'h11, 8'h44, 0, 1, 0, 0, 0);
    @(posedge clk); #1; start = 1; rd = 1; addr = 10'h3FF; tag = "R1";
    @(posedge clk); #1; start = 0; idle(2);
    tx_data = 8'h22;
    ev("R4", 8'h28, 0, 1, 8'h22, 8'h44, 0, 1, 0, 0, 0);
    ev("R4", 8'h28, 0, 0, 0, 8'h54, 0, 0, 0, 1, 0);
    idle(2);

    // R3 R7: 10-bit read 0x2A5, two bytes
    go("R1", 1, 1, 10'h2A5, 2);
    ev("R2", 8'h08, 0, 1, 8'hF5, 8'h44, 0, 0, 0, 0, 0);
    ev("R3", 8'h40, 0, 1, 8'hA5, 8'h44, 0, 0, 0, 0, 0);
    ev("R6", 8'hE0, 0, 0, 0, 8'h44, 0, 0, 0, 0, 0);
    ev("R7", 8'h50, 8'h3C, 0, 0, 8'h40, 0, 0, 1, 0, 0);
    ev("R7", 8'h58, 8'h7E, 0, 0, 8'h50, 0, 0, 1, 1, 0);

    // R6 probe: 7-bit read 0x21, zero length
    go("R6", 1, 0, 10'h021, 0);
    ev("R2", 8'h10, 0, 1, 8'h43, 8'h44, 0, 0, 0, 0, 0);
    ev("R6", 8'h40, 0, 0, 0, 8'h54, 0, 0, 0, 1, 0);

    // R7 one-byte read: ACK dropped at address ack
    go("R7", 1, 0, 10'h011, 1);
    ev("R2", 8'h08, 0, 1, 8'h23, 8'h44, 0, 0, 0, 0, 0);
    ev("R7", 8'h40, 0, 0, 0, 8'h40, 0, 0, 0, 0, 0);
    ev("R7", 8'h58, 8'h5A, 0, 0, 8'h50, 0, 0, 1, 1, 0);

    // R8 no device
    go("R8", 0, 0, 10'h012, 1);
    ev("R2", 8'h08, 0, 1, 8'h24, 8'h44, 0, 0, 0, 0, 0);
    ev("R8", 8'h20, 0, 0, 0, 8'h54, 0, 0, 0, 1, 1);
    idle(3);                                   // R12: err held at 1

    // R9 illegal status
    go("R9", 0, 0, 10'h012, 1);
    ev("R9", 8'h38, 0, 0, 0, 8'h50, 1, 0, 0, 1, 2);

    // R11 leftover flag while idle
    ev("R11", 8'h08, 0, 0, 0, 8'h50, 0, 0, 0, 0, 2);

    // R5 abort after one written byte
    go("R5", 0, 0, 10'h033, 3);
    ev("R2", 8'h08, 0, 1, 8'h66, 8'h44, 0, 0, 0, 0, 0);
    tx_data = 8'h9C;
    ev("R4", 8'h18, 0, 1, 8'h9C, 8'h44, 0, 1, 0, 0, 0);
    abort = 1;
    ev("R5", 8'h28, 0, 0, 0, 8'h54, 0, 0, 0, 1, 0);
    abort = 0;

    // R5 R3 abort before any byte: 10-bit write 0x3FF, one byte still sent
    go("R3", 0, 1, 10'h3FF, 1);
    abort = 1;
    ev("R2", 8'h08, 0, 1, 8'hF6, 8'h44, 0, 0, 0, 0, 0);
    ev("R3", 8'h18, 0, 1, 8'hFF, 8'h44, 0, 0, 0, 0, 0);
    tx_data = 8'hB7;
    ev("R5", 8'hD0, 0, 1, 8'hB7, 8'h44, 0, 1, 0, 0, 0);
    ev("R4", 8'h28, 0, 0, 0, 8'h54, 0, 0, 0, 1, 0);
    abort = 0;

    // R7 read abort: ACK dropped early
    go("R7", 1, 0, 10'h010, 4);
    ev("R2", 8'h08, 0, 1, 8'h21, 8'h44, 0, 0, 0, 0, 0);
    abort = 1;
    ev("R7", 8'h40, 0, 0, 0, 8'h40, 0, 0, 0, 0, 0);
    ev("R7", 8'h58, 8'hE1, 0, 0, 8'h50, 0, 0, 1, 1, 0);
    abort = 0;

    // R13 flag held high after a reply is not acted on again
    go("R13", 0, 0, 10'h001, 1);
    @(posedge clk); #1; eng_iflg = 1; eng_status = 8'h08;
    @(posedge clk); #1; tag = "R13"; x_dwe = 1; x_d = 8'h02; x_cwe = 1; x_c = 8'h44;
    @(posedge clk); #1; clr;
    idle(3);
    eng_iflg = 0; idle(2);
    ev("R8", 8'h30, 0, 0, 0, 8'h54, 0, 0, 0, 1, 1);
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule